// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Scheduler

This block keeps an FPM or EDO DRAM array alive by issuing CAS-before-RAS refresh cycles at a programmed spacing. An interval counter runs freely and records an expiry in a single pending flag every `cfg_interval` memory clocks. When a request is pending and no access is in progress, the block takes the strobes. It drives CAS low to every bank, then pulls each bank's RAS low one clock after the previous bank's. It releases every strobe together once the last bank has held RAS for the programmed width.

The access sequencer reports an in-progress access on `acc_busy` and marks the final cycle of that access with `acc_done`. A refresh never interrupts an access. It waits behind the access and starts right after it. While `ref_busy` is high the sequencer must not begin a new access. Boot code loads the interval and RAS width and then raises `enable`. No refresh is issued before that.

Top module: `dram_refresh_sched`

## Requirements
- R1: Out of synchronous reset every `ras_n` bit and `cas_n` are high and `ref_busy` is low.
- R2: With `enable` high and `cfg_interval` = I > 0, the interval counter expires every I clocks, counting from the first enabled clock. A refresh whose request is not deferred drives `cas_n` low in the clock after the expiry, that is I+1 clocks after the first enabled edge.
- R3: While `enable` is low or `cfg_interval` is zero, the counter and the pending request are cleared and no refresh starts. A refresh already running completes normally.
- R4: `cas_n` goes low exactly one clock before bank 0's `ras_n`, and no `ras_n` bit is ever low while `cas_n` is high.
- R5: Bank k's `ras_n` (bit k) goes low exactly one clock after bank k-1's, in ascending bank order.
- R6: The last bank's `ras_n` stays low for W clocks, where W is `cfg_ras_width` sampled when the refresh starts and a value of 0 counts as 1. All `ras_n` bits and `cas_n` then return high on the same edge.
- R7: No refresh starts in a cycle where `acc_busy` is high and `acc_done` is low. A pending refresh starts on the edge that ends a cycle with `acc_done` high or `acc_busy` low.
- R8: The interval counter reloads on expiry, whether or not the request is served, so a deferral does not shift later expiries.
- R9: `ref_busy` is high in exactly the cycles in which `cas_n` is low.
- R10: An expiry that occurs while a refresh runs or while a request is deferred sets the single pending flag and is served afterwards. Further expiries before service merge into that one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows refresh once configuration is loaded |
| cfg_interval | input | INTERVAL_W | Clocks between refresh requests; 0 disables |
| cfg_ras_width | input | RASW_W | RAS low time per bank during refresh; 0 means 1 |
| acc_busy | input | 1 | Access sequencer has an access in progress |
| acc_done | input | 1 | Final cycle of the current access |
| ras_n | output | NUM_BANKS | Per-bank RAS strobes, active low |
| cas_n | output | 1 | CAS strobe shared by all banks, active low |
| ref_busy | output | 1 | Refresh owns the strobes |

## Verification
The embedded properties check on every cycle the strobe ordering (CAS before any RAS, each bank after its lower neighbour), the joint release of all strobes, the agreement of `ref_busy` with CAS, and that no refresh begins during an access or while disabled. Only the bench's scenarios can show the exact start time after the interval expires, the exact widths with zero and non-zero settings, the merging of expiries and the absence of drift. These scenarios include back-to-back expiries during a long refresh and a request deferred behind a long access. In them, a behavioural timeline model predicts every strobe in every cycle.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CAS  = 2'd1,
    SEQ_RAS  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic [INTERVAL_W-1:0] interval,
  input  logic                  consume,
  output logic                  pending
);
  logic [INTERVAL_W-1:0] count_q;
  logic                  pend_q;
  logic                  active;
  logic                  expire;

  assign active = enable && (interval != '0);
  assign expire = active && (count_q == interval - INTERVAL_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      pend_q  <= 1'b0;
    end else if (!active) begin
      count_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      // reload on expiry regardless of service (R8)
      count_q <= expire ? '0 : count_q + INTERVAL_W'(1);
      // expiry wins over consume; extra expiries merge (R10)
      if (expire)       pend_q <= 1'b1;
      else if (consume) pend_q <= 1'b0;
    end
  end

  assign pending = pend_q;

  // R3: nothing may be pending one cycle after the counter was inactive
  assert_idle_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pend_q);
  // R8: the counter never runs past the programmed interval
  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    active |-> (count_q < interval));
endmodule

// File: rtl/refresh_strobe_seq.sv
module refresh_strobe_seq
  import dram_refresh_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int RASW_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [RASW_W-1:0]    width,
  output logic [NUM_BANKS-1:0] ras_n,
  output logic                 cas_n,
  output logic                 busy,
  output logic                 idle
);
  localparam int TW = $clog2(NUM_BANKS + (1 << RASW_W) + 2);

  seq_state_t          state_q;
  logic [TW-1:0]       step_q;
  logic [RASW_W-1:0]   width_q;
  logic [NUM_BANKS-1:0] ras_q;
  logic                cas_q;
  logic                busy_q;
  logic [TW-1:0]       release_at;

  assign release_at = TW'(NUM_BANKS - 1) + TW'(width_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      step_q  <= '0;
      width_q <= RASW_W'(1);
      ras_q   <= '1;
      cas_q   <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_CAS;
            cas_q   <= 1'b0;
            busy_q  <= 1'b1;
            // zero width is stretched to one clock (R6)
            width_q <= (width == '0) ? RASW_W'(1) : width;
          end
        end
        SEQ_CAS: begin
          ras_q[0] <= 1'b0;
          step_q   <= TW'(1);
          state_q  <= SEQ_RAS;
        end
        SEQ_RAS: begin
          if (step_q == release_at) begin
            ras_q   <= '1;
            cas_q   <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= SEQ_IDLE;
          end else begin
            step_q <= step_q + TW'(1);
            for (int k = 1; k < NUM_BANKS; k++) begin
              if (step_q == TW'(k)) ras_q[k] <= 1'b0;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ras_n = ras_q;
  assign cas_n = cas_q;
  assign busy  = busy_q;
  assign idle  = (state_q == SEQ_IDLE);

  // R4: any RAS low requires CAS low
  assert_cas_first_R4: assert property (@(posedge clk) disable iff (rst)
    (ras_q != '1) |-> !cas_q);
  // R4: bank 0 falls one clock after CAS did
  assert_cas_lead_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_q[0]) |-> ($past(!cas_q) && $past(ras_q == '1)));
  // R6: strobes release together after every bank was low
  assert_joint_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_q) |-> ((ras_q == '1) && $past(ras_q == '0)));
  // R9: busy tracks CAS
  assert_busy_cas_R9: assert property (@(posedge clk) disable iff (rst)
    busy_q == !cas_q);

  genvar g;
  generate
    for (g = 1; g < NUM_BANKS; g++) begin : g_order
      // R5: bank g falls only after bank g-1 was already low
      assert_stagger_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_q[g]) |-> ($past(!ras_q[g-1]) && $past(ras_q[g])));
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int NUM_BANKS  = 4,
  parameter int INTERVAL_W = 16,
  parameter int RASW_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic [INTERVAL_W-1:0] cfg_interval,
  input  logic [RASW_W-1:0]     cfg_ras_width,
  input  logic                  acc_busy,
  input  logic                  acc_done,
  output logic [NUM_BANKS-1:0]  ras_n,
  output logic                  cas_n,
  output logic                  ref_busy
);
  logic pending;
  logic seq_idle;
  logic start;
  logic bus_free;

  assign bus_free = !acc_busy || acc_done;
  assign start    = seq_idle && pending && enable && bus_free;

  refresh_interval_timer #(.INTERVAL_W(INTERVAL_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .interval (cfg_interval),
    .consume  (start),
    .pending  (pending)
  );

  refresh_strobe_seq #(.NUM_BANKS(NUM_BANKS), .RASW_W(RASW_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .width (cfg_ras_width),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .busy  (ref_busy),
    .idle  (seq_idle)
  );

  // R7: a refresh begins only when the access bus was free
  assert_defer_access_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> $past(!acc_busy || acc_done));
  // R3: a refresh begins only when enabled with a non-zero interval
  assert_enabled_start_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> $past(enable && (cfg_interval != '0)));
endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
  localparam int NB = 4;
  localparam int IW = 16;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [IW-1:0] cfg_interval = '0;
  logic [WW-1:0] cfg_ras_width = '0;
  logic          acc_busy = 1'b0;
  logic          acc_done = 1'b0;
  logic [NB-1:0] ras_n;
  logic          cas_n;
  logic          ref_busy;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  bit model_on = 0;

  always #10 clk = ~clk;  // 50 MHz

  dram_refresh_sched #(.NUM_BANKS(NB), .INTERVAL_W(IW), .RASW_W(WW)) dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_interval(cfg_interval),
    .cfg_ras_width(cfg_ras_width), .acc_busy(acc_busy), .acc_done(acc_done),
    .ras_n(ras_n), .cas_n(cas_n), .ref_busy(ref_busy));

  // Behavioural timeline model: a refresh is a phase index p counted from
  // its start edge; strobe levels are read off that index.
  int m_cnt = 0;
  bit m_pend = 0;
  bit m_act = 0;
  int m_p = 0;
  int m_w = 1;
  int m_starts = 0;
  int d_starts = 0;

  function automatic bit exp_cas_low();
    return m_act && (m_p <= NB + m_w - 1);
  endfunction
  function automatic bit exp_ras_low(int k);
    return m_act && (m_p >= 1 + k) && (m_p <= NB + m_w - 1);
  endfunction

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (rst) begin
      m_cnt = 0; m_pend = 0; m_act = 0; m_p = 0;
    end else begin
      bit fire;
      fire = 0;
      if (m_act) begin
        m_p++;
        if (m_p == NB + m_w) m_act = 0;
      end else if (m_pend && enable && (!acc_busy || acc_done)) begin
        fire = 1;
        m_act = 1; m_p = 0;
        m_w = (cfg_ras_width == 0) ? 1 : int'(cfg_ras_width);
        m_starts++;
      end
      if (fire) m_pend = 0;
      if (enable && cfg_interval != 0) begin
        if (m_cnt == int'(cfg_interval) - 1) begin
          m_cnt = 0; m_pend = 1;
        end else m_cnt++;
      end else begin
        m_cnt = 0; m_pend = 0;
      end
    end
  end

  logic prev_cas = 1'b1;
  always @(negedge clk) begin
    if (!rst && prev_cas && !cas_n) d_starts++;
    prev_cas <= cas_n;
    if (model_on && !rst) begin
      check(cas_n == !exp_cas_low(), "R4", int'(cas_n), int'(!exp_cas_low()));
      check(ref_busy == exp_cas_low(), "R9", int'(ref_busy), int'(exp_cas_low()));
      for (int k = 0; k < NB; k++) begin
        check(ras_n[k] == !exp_ras_low(k), (k == 0) ? "R6" : "R5",
              int'(ras_n[k]), int'(!exp_ras_low(k)));
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycle, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int base;
  int seen_fall;

  initial begin
    tick(3);
    // R1: reset values
    check(ras_n == '1, "R1", int'(ras_n), 15);
    check(cas_n == 1'b1, "R1", int'(cas_n), 1);
    check(ref_busy == 1'b0, "R1", int'(ref_busy), 0);
    rst = 1'b0;
    model_on = 1;

    // R3: disabled with interval programmed: nothing happens
    cfg_interval = 16'd8; cfg_ras_width = 4'd2;
    tick(40);
    check(d_starts == 0, "R3", d_starts, 0);

    // R2: first CAS low I+1 clocks after the first enabled edge
    enable = 1'b1;
    seen_fall = -1;
    for (int i = 1; i <= 12; i++) begin
      tick(1);
      if (seen_fall < 0 && !cas_n) seen_fall = i;
    end
    check(seen_fall == 9, "R2", seen_fall, 9);
    tick(100);
    check(d_starts == m_starts, "R2", d_starts, m_starts);

    // R6: width zero is stretched to one clock
    cfg_ras_width = 4'd0;
    tick(60);
    // R6: maximum width
    cfg_ras_width = 4'd15;
    cfg_interval = 16'd40;
    tick(200);

    // R10: interval shorter than a refresh, expiries merge
    cfg_interval = 16'd5; cfg_ras_width = 4'd6;
    tick(120);
    check(d_starts == m_starts, "R10", d_starts, m_starts);

    // R7: long access holds off refresh
    cfg_interval = 16'd20; cfg_ras_width = 4'd3;
    tick(30);
    base = d_starts;
    acc_busy = 1'b1;
    tick(50);
    check(d_starts == base || cas_n == 1'b1, "R7", int'(cas_n), 1);
    acc_done = 1'b1; tick(1); acc_done = 1'b0; acc_busy = 1'b0;
    tick(2);
    check(cas_n == 1'b0, "R7", int'(cas_n), 0);
    // R8: no drift after deferral, expiries stay on the original grid
    tick(200);
    check(d_starts == m_starts, "R8", d_starts, m_starts);

    // R3: interval zero stops requests; running refresh finishes
    cfg_interval = 16'd0;
    tick(30);
    base = d_starts;
    tick(100);
    check(d_starts == base, "R3", d_starts, base);
    // R3: disable clears a pending request
    cfg_interval = 16'd7;
    acc_busy = 1'b1;
    tick(20);
    enable = 1'b0;
    acc_busy = 1'b0;
    tick(40);
    check(cas_n == 1'b1, "R3", int'(cas_n), 1);
    check(d_starts == m_starts, "R3", d_starts, m_starts);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog at cycle %0d: actual=running expected=done", cycle);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule